// File: doc/BRIEF.md
# DMA Completion Response Buffer

This block sits at the completion end of a descriptor-driven DMA engine. Each time a descriptor finishes, the engine pushes one response record into the block: the number of bytes actually moved, an eight-bit error code, an early-termination flag, and three interrupt enables that travel with that descriptor. The block also samples a descriptor-queue-full status input at push time and stores it in the record. Records wait in a small FIFO until software reads them.

Software sees the head record through a read-only, word-addressed, 32-bit memory-mapped port with one address bit. A complete record therefore takes two reads. A read of the status word that enables the top byte lane retires the head record. Software must read the byte count first and the status word last. The block also drives a level interrupt from a sticky status bit. Hardware sets that bit and software clears it by writing a one. If both happen in the same cycle, the hardware set wins.

Top module: `dma_resp_buffer`

## Requirements
- R1: After reset the FIFO is empty, `rd_data` is 0, `irq_line` is 0 and `ovf_flag` is 0.
- R2: A read accepted at address 0 returns the head record's byte count on `rd_data` one clock after the accepting edge. Each byte lane i (bits 8i+7:8i) reads as zero when `rd_be[i]` is 0.
- R3: A read accepted at address 1 returns the status word one clock later, with the same lane masking. The word holds the error code in bits 7:0, early termination in bit 8, the completion interrupt enable in bit 9, the error interrupt enables in bits 17:10, the early-termination interrupt enable in bit 18, the stored queue-full status in bit 19, and zeros in bits 31:20.
- R4: An accepted read at address 1 with `rd_be[3]`=1 removes the head record. Reads at address 0, and reads at address 1 with `rd_be[3]`=0, leave the record in place.
- R5: `rd_wait` is high in any cycle where `rd_strobe` is high and the FIFO is empty. Such a read is not accepted and `rd_data` keeps its value. `rd_data` also keeps its value whenever no read is accepted.
- R6: The FIFO holds `DEPTH` records (default 4) and returns them in push order. A push arriving while the FIFO is full is discarded. A discarded push sets `ovf_flag`, which stays set until reset. A push and a pop in the same cycle are both performed when the FIFO is not full.
- R7: A push raises the interrupt status bit on the next clock when any of these holds: the completion enable is set; the early-termination flag and its enable are both set; or any error bit is set together with its matching error enable. The interrupt status bit does not rise otherwise.
- R8: Software clears the interrupt status bit by pulsing `irq_clr_wr` with `irq_clr_data`=1. A pulse with `irq_clr_data`=0 has no effect.
- R9: When an interrupt-raising push and a clear arrive in the same cycle, the status bit ends up set.
- R10: `irq_line` follows the status bit and stays high until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push one completion record |
| push_bytes | input | 32 | Bytes actually transferred |
| push_err | input | 8 | Error code bits |
| push_early | input | 1 | Transfer ended early |
| push_en_done | input | 1 | Completion interrupt enable |
| push_en_err | input | 8 | Per-bit error interrupt enables |
| push_en_early | input | 1 | Early-termination interrupt enable |
| desc_full | input | 1 | Descriptor queue full status, stored at push |
| rd_strobe | input | 1 | Read request |
| rd_addr | input | 1 | Word address (0 byte count, 1 status word) |
| rd_be | input | 4 | Read byte lane enables |
| rd_data | output | 32 | Registered read data |
| rd_wait | output | 1 | Read cannot be answered this cycle |
| irq_clr_wr | input | 1 | Interrupt status write strobe |
| irq_clr_data | input | 1 | Write data bit 0; 1 clears the status |
| irq_line | output | 1 | Level interrupt |
| ovf_flag | output | 1 | Sticky: a push was discarded |

## Verification
A read or write pointer in the wrong state shows up on the read after the next pop. That read returns a record out of push order or a stale record, one clock after it is accepted. A wrong occupancy count shows up in one of two ways. Either `rd_wait` rises while records remain, or it stays low on an empty FIFO. Or `ovf_flag` sets too early or too late on a fill to capacity. A wrong interrupt status shows on `irq_line` on the clock after the push or clear that should have changed it, and it persists until the next clear.

// File: rtl/rspbuf_pkg.sv
package rspbuf_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int ERR_W   = 8;
    localparam int STAT_W  = 2 * ERR_W + 4;

    typedef struct packed {
        logic [DATA_W-1:0] bytes;
        logic [ERR_W-1:0]  err;
        logic              early;
        logic              en_done;
        logic [ERR_W-1:0]  en_err;
        logic              en_early;
        logic              dfull;
    } rsp_t;

    // Status word: err 7:0, early 8, en_done 9, en_err 17:10, en_early 18, dfull 19
    function automatic logic [DATA_W-1:0] status_word(input rsp_t r);
        return {{(DATA_W-STAT_W){1'b0}}, r.dfull, r.en_early, r.en_err,
                r.en_done, r.early, r.err};
    endfunction

    function automatic logic raises_irq(input rsp_t r);
        return r.en_done | (r.en_early & r.early) | (|(r.en_err & r.err));
    endfunction

endpackage

// File: rtl/rspbuf_fifo.sv
module rspbuf_fifo
    import rspbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  rsp_t push_data,
    input  logic pop,
    output rsp_t head,
    output logic empty,
    output logic full,
    output logic overflow
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    rsp_t           mem [DEPTH];
    logic [AW-1:0]  wptr, rptr;
    logic [CW-1:0]  count;
    logic           push_ok, pop_ok;

    function automatic logic [AW-1:0] advance(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        empty   = (count == '0);
        full    = (count == CAP);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem[rptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wptr <= advance(wptr);
            if (pop_ok)  rptr <= advance(rptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
            if (push && full) overflow <= 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CAP); // R6
    AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && overflow)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow); // R6

endmodule

// File: rtl/rspbuf_rdport.sv
module rspbuf_rdport
    import rspbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_strobe,
    input  logic              rd_addr,
    input  logic [LANES-1:0]  rd_be,
    input  rsp_t              head,
    input  logic              empty,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_wait,
    output logic              pop
);

    logic              accept;
    logic [DATA_W-1:0] word, lane_mask;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_mask[8*i +: 8] = {8{rd_be[i]}};
    end

    always_comb begin
        accept  = rd_strobe && !empty;
        rd_wait = rd_strobe && empty;
        pop     = accept && rd_addr && rd_be[LANES-1];
        word    = rd_addr ? status_word(head) : head.bytes;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (accept) begin
            rd_data <= word & lane_mask;
        end
    end

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe || empty) |=> $stable(rd_data)); // R5

endmodule

// File: rtl/rspbuf_irq.sv
module rspbuf_irq
    import rspbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic push_valid,
    input  rsp_t push_data,
    input  logic clr_wr,
    input  logic clr_data,
    output logic status
);

    logic set_ev, clr_ev;

    always_comb begin
        set_ev = push_valid && raises_irq(push_data);
        clr_ev = clr_wr && clr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= 1'b0;
        end else begin
            status <= set_ev | (status & ~clr_ev);
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_ev |=> status); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (status && clr_ev && !set_ev) |=> !status); // R8
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (status && !clr_ev) |=> status); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (!status && !set_ev) |=> !status); // R7

endmodule

// File: rtl/dma_resp_buffer.sv
module dma_resp_buffer
    import rspbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_valid,
    input  logic [31:0] push_bytes,
    input  logic [7:0]  push_err,
    input  logic        push_early,
    input  logic        push_en_done,
    input  logic [7:0]  push_en_err,
    input  logic        push_en_early,
    input  logic        desc_full,
    input  logic        rd_strobe,
    input  logic        rd_addr,
    input  logic [3:0]  rd_be,
    output logic [31:0] rd_data,
    output logic        rd_wait,
    input  logic        irq_clr_wr,
    input  logic        irq_clr_data,
    output logic        irq_line,
    output logic        ovf_flag
);

    rsp_t rec_in, rec_head;
    logic fifo_empty, fifo_full, rd_pop;

    always_comb begin
        rec_in.bytes    = push_bytes;
        rec_in.err      = push_err;
        rec_in.early    = push_early;
        rec_in.en_done  = push_en_done;
        rec_in.en_err   = push_en_err;
        rec_in.en_early = push_en_early;
        rec_in.dfull    = desc_full;
    end

    rspbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push_valid),
        .push_data (rec_in),
        .pop       (rd_pop),
        .head      (rec_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overflow  (ovf_flag)
    );

    rspbuf_rdport u_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd_strobe (rd_strobe),
        .rd_addr   (rd_addr),
        .rd_be     (rd_be),
        .head      (rec_head),
        .empty     (fifo_empty),
        .rd_data   (rd_data),
        .rd_wait   (rd_wait),
        .pop       (rd_pop)
    );

    rspbuf_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .push_valid (push_valid),
        .push_data  (rec_in),
        .clr_wr     (irq_clr_wr),
        .clr_data   (irq_clr_data),
        .status     (irq_line)
    );

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        rd_pop |-> (!fifo_empty && !rd_wait)); // R4
    AST_WAIT_BLOCKS_POP: assert property (@(posedge clk) disable iff (rst)
        rd_wait |-> !rd_pop); // R5

endmodule

// File: tb/test_dma_resp_buffer.sv
`timescale 1ns/1ps
module test_dma_resp_buffer;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_valid, push_early, push_en_done, push_en_early, desc_full;
    logic [31:0] push_bytes;
    logic [7:0]  push_err, push_en_err;
    logic        rd_strobe, rd_addr;
    logic [3:0]  rd_be;
    logic [31:0] rd_data;
    logic        rd_wait, irq_clr_wr, irq_clr_data, irq_line, ovf_flag;

    dma_resp_buffer #(.DEPTH(DEPTH)) i_dma_resp_buffer (
        .clk(clk), .rst(rst),
        .push_valid(push_valid), .push_bytes(push_bytes), .push_err(push_err),
        .push_early(push_early), .push_en_done(push_en_done),
        .push_en_err(push_en_err), .push_en_early(push_en_early),
        .desc_full(desc_full),
        .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_be(rd_be),
        .rd_data(rd_data), .rd_wait(rd_wait),
        .irq_clr_wr(irq_clr_wr), .irq_clr_data(irq_clr_data),
        .irq_line(irq_line), .ovf_flag(ovf_flag)
    );

    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] q_bytes[$];
    logic [31:0] q_stat[$];
    logic [31:0] exp_rdata = '0;
    logic        exp_irq = 1'b0;
    logic        exp_ovf = 1'b0;

    function automatic logic [31:0] mk_stat(input logic [7:0] e, input logic early,
        input logic md, input logic [7:0] me, input logic mearly, input logic df);
        return {12'b0, df, mearly, me, md, early, e};
    endfunction

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic irq_cause(input logic [7:0] e, input logic early,
        input logic md, input logic [7:0] me, input logic mearly);
        return md | (early & mearly) | (|(e & me));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        push_valid = 0; push_bytes = '0; push_err = '0; push_early = 0;
        push_en_done = 0; push_en_err = '0; push_en_early = 0; desc_full = 0;
        rd_strobe = 0; rd_addr = 0; rd_be = 4'hF;
        irq_clr_wr = 0; irq_clr_data = 0;
    endtask

    task automatic set_push(input logic [31:0] b, input logic [7:0] e, input logic early,
        input logic md, input logic [7:0] me, input logic mearly, input logic df);
        push_valid = 1; push_bytes = b; push_err = e; push_early = early;
        push_en_done = md; push_en_err = me; push_en_early = mearly; desc_full = df;
    endtask

    task automatic set_read(input logic a, input logic [3:0] be);
        rd_strobe = 1; rd_addr = a; rd_be = be;
    endtask

    // One clock: inputs are set at a falling edge; check and advance the model.
    task automatic step();
        bit acc, do_pop, was_full, ev, clr;
        #1;
        chk("R5 rd_wait", {31'b0, rd_wait}, {31'b0, rd_strobe && (q_bytes.size() == 0)});
        acc      = rd_strobe && (q_bytes.size() != 0);
        do_pop   = acc && rd_addr && rd_be[3];
        was_full = (q_bytes.size() >= DEPTH);
        if (acc) exp_rdata = (rd_addr ? q_stat[0] : q_bytes[0]) & be_mask(rd_be);
        ev  = push_valid && irq_cause(push_err, push_early, push_en_done, push_en_err, push_en_early);
        clr = irq_clr_wr && irq_clr_data;
        exp_irq = ev | (exp_irq & ~clr);
        if (do_pop) begin
            void'(q_bytes.pop_front());
            void'(q_stat.pop_front());
        end
        if (push_valid) begin
            if (was_full) exp_ovf = 1'b1;
            else begin
                q_bytes.push_back(push_bytes);
                q_stat.push_back(mk_stat(push_err, push_early, push_en_done,
                                         push_en_err, push_en_early, desc_full));
            end
        end
        @(negedge clk);
        chk("R2,R3,R4,R6 rd_data", rd_data, exp_rdata);
        chk("R7,R8,R9,R10 irq_line", {31'b0, irq_line}, {31'b0, exp_irq});
        chk("R6 ovf_flag", {31'b0, ovf_flag}, {31'b0, exp_ovf});
        idle();
    endtask

    initial begin
        #(100000 * 4);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog expired: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 irq_line", {31'b0, irq_line}, 32'h0);
        chk("R1 ovf_flag", {31'b0, ovf_flag}, 32'h0);
        // R5: read on empty waits
        set_read(1, 4'hF); step();

        // R2, R3, R4: one record, masked reads, non-destructive then destructive
        set_push(32'hA1B2_C3D4, 8'h5A, 1, 0, 8'h00, 1, 1); step();
        set_read(0, 4'hF); step();                 // R2 word 0
        set_read(0, 4'b0101); step();              // R2 lane mask
        set_read(1, 4'b0111); step();              // R4 no pop, R3 layout
        set_read(1, 4'hF); step();                 // R3 and R4 pop
        set_read(0, 4'hF); step();                 // R5 now empty
        irq_clr_wr = 1; irq_clr_data = 1; step();

        // R7: error bit without matching enable does not raise
        set_push(32'd10, 8'h01, 0, 0, 8'h02, 0, 0); step();
        // R7: matching error enable raises
        set_push(32'd11, 8'h01, 0, 0, 8'h01, 0, 0); step();
        // R8: clear with data 0 has no effect
        irq_clr_wr = 1; irq_clr_data = 0; step();
        // R9: set wins over simultaneous clear
        set_push(32'd12, 8'h00, 0, 1, 8'h00, 0, 0);
        irq_clr_wr = 1; irq_clr_data = 1; step();
        // R10: stays high while idle
        step(); step();
        // R8: clear works
        irq_clr_wr = 1; irq_clr_data = 1; step();

        // R6: fill past capacity, then drain in order
        for (int i = 0; i < DEPTH + 2; i++) begin
            set_push(32'h100 + i, 8'h00, 0, 0, 8'h00, 0, 0); step();
        end
        // R6: push and pop in same cycle while full: push dropped
        set_push(32'h999, 8'h00, 0, 0, 8'h00, 0, 0); set_read(1, 4'hF); step();
        for (int i = 0; i < DEPTH + 1; i++) begin
            set_read(0, 4'hF); step();
            set_read(1, 4'h8); step();
        end

        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 9) < 3)
                set_push($urandom(), ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h00,
                         1'($urandom()), 1'($urandom_range(0, 3) == 0),
                         8'($urandom()), 1'($urandom()), 1'($urandom()));
            if ($urandom_range(0, 1) == 1)
                set_read(1'($urandom()), ($urandom_range(0, 1) == 1) ? 4'hF : 4'($urandom()));
            if ($urandom_range(0, 9) == 0) begin
                irq_clr_wr = 1; irq_clr_data = 1'($urandom());
            end
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule